// File: doc/BRIEF.md
# Synchronous Serial Receiver with Sync-Character Hunt

This block recovers characters from a bit-serial synchronous line that carries no start or stop bits. Character boundaries are found by hunting: after a command with the hunt bit set, every received bit is shifted into a window register. The window is compared against a programmed sync character after each bit. When they match, the boundary is known. The sync character itself is dropped, and the following bits are assembled into data characters of 5 to 8 bits. A parity bit may follow each character. Completed characters go to a one-entry receive buffer with a ready flag. The block also raises an overrun flag and a parity-error flag.

A sync-detect status bit reports that the sync pattern has been seen. In internal-sync mode this bit is also driven onto a sync-detect pin. In external-sync mode the pin turns into an input. A rising edge on that input aligns the receiver in place of the pattern compare. The receive clock and the sync input are sampled in the system clock domain and edge-detected there. A host-side controller supplies the decoded mode fields and the command, status-read and data-read pulses.

Top module: `sync_hunt_rx`

## Requirements
- R1: A bit is taken from `rxd` only in the system clock cycle in which a rising edge of `rxc` is detected, and only while `rx_enable` is 1. Edges of `rxc` that occur while `rx_enable` is 0 leave the assembly state untouched.
- R2: Characters arrive least-significant bit first. `len_code` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. A completed character appears on `rx_data`, zero-extended, and sets `rx_ready`. A `data_rd` pulse clears `rx_ready`.
- R3: A `cmd_wr` pulse with `cmd_hunt` set clears the window and raises `hunting`. While hunting, the window is compared with `sync_char` (masked to the character length) after every bit. A match clears `hunting` and aligns the next character, and the sync character is not delivered.
- R4: With `parity_en` set, the bit after the last data bit is a parity bit. `parity_even` = 1 expects the XOR of the data bits, and 0 expects its inverse. A mismatch sets `parity_err`, and the character is still delivered. After a hunt match, the sync character's own parity bit is consumed without a check.
- R5: Whenever a completed data character equals the sync character, `syndet` is set and the character is still delivered.
- R6: `syndet` clears on a `status_rd` pulse and on any `cmd_wr` pulse. When a set event falls in the same cycle, the set wins.
- R7: With `ext_sync_mode` set, no bits are taken after reset or after a hunt command until a rising edge on `syn_in`. That edge clears `hunting`, aligns the receiver and sets `syndet`.
- R8: In internal mode `syndet_oe` is 1 and `syndet_out` equals `syndet`. In external mode `syndet_oe` is 0.
- R9: A character delivered while `rx_ready` is 1 and no `data_rd` occurs in the same cycle sets `overrun_err`. The new character still replaces `rx_data`.
- R10: After reset, `rx_ready`, `parity_err`, `overrun_err`, `syndet` and `hunting` are 0. A `cmd_wr` pulse with `cmd_err_clr` set clears `parity_err` and `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxc | input | 1 | Receive bit clock, sampled on its rising edge |
| rxd | input | 1 | Serial receive data |
| rx_enable | input | 1 | Receive-enable command bit |
| len_code | input | 2 | Character length code (0..3 gives 5..8 bits) |
| parity_en | input | 1 | Parity bit present and checked |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| ext_sync_mode | input | 1 | 1 selects external sync alignment |
| sync_char | input | 8 | Programmed sync character |
| syn_in | input | 1 | External sync input, active on its rising edge |
| cmd_wr | input | 1 | Command write pulse |
| cmd_hunt | input | 1 | Hunt bit of the command |
| cmd_err_clr | input | 1 | Error-reset bit of the command |
| status_rd | input | 1 | Status read pulse |
| data_rd | input | 1 | Receive data read pulse |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| parity_err | output | 1 | Sticky parity error flag |
| overrun_err | output | 1 | Sticky overrun flag |
| syndet | output | 1 | Sync-detect status bit |
| hunting | output | 1 | Hunt mode active |
| syndet_out | output | 1 | Sync-detect pin output value |
| syndet_oe | output | 1 | Sync-detect pin output enable |

## Verification
The assertions check several rules on every cycle. The window register holds still unless a qualified bit edge or a command arrives. The bit counter never passes the frame length. A rise of `rx_ready` always follows a delivery. Overrun follows an unread delivery. `syndet` drops after a status read that has no competing set. No bit is accepted in external mode before the sync input has fired. The bench scenarios are the only place that shows the values themselves: that LSB-first assembly yields the right byte for each length, that the hunt window finds the pattern at an arbitrary bit offset and discards it, that parity polarity is right, and that sync-pattern data characters are both delivered and flagged.

// File: rtl/sync_hunt_rx_pkg.sv
// Package: shared types for the synchronous hunt receiver.
// Assumes: characters are at most 8 bits plus one parity bit.
package sync_hunt_rx_pkg;
    typedef enum logic [1:0] {
        PH_HUNT      = 2'd0,  // sliding compare against the sync pattern
        PH_SKIP_PAR  = 2'd1,  // discard the parity bit of the matched sync
        PH_DATA      = 2'd2,  // assembling data bits
        PH_PARITY    = 2'd3   // next bit is the parity bit
    } rx_phase_e;
endpackage

// File: rtl/sr_rise_detect.sv
// Module: sr_rise_detect
// Registers a slow level input once and flags the cycle in which it is
// seen high after having been low. Assumes the input is already
// synchronous to clk, or that the caller has synchronised it.
module sr_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    // Holds the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/sr_deframer.sv
// Module: sr_deframer
// Bit-level engine. It hunts for the sync pattern in a sliding window,
// then assembles LSB-first characters of 5..8 bits with an optional
// parity bit. It emits single-cycle pulses for delivery, parity fault and
// sync sighting. Assumes bit_strobe is already qualified by enable and
// arming, and never coincides with cmd_wr.
module sr_deframer
    import sync_hunt_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              rxd,
    input  logic [1:0]        len_code,
    input  logic              parity_en,
    input  logic              parity_even,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              cmd_wr,
    input  logic              cmd_hunt,
    input  logic              force_align,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              parity_bad,
    output logic              sync_seen,
    output logic              hunting
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(DATA_W + 2);

    rx_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_next;
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] sync_masked;
    logic [IDX_W-1:0]  top_idx;
    logic              last_data;
    logic              window_hit;
    logic              par_expect;

    assign top_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(len_code);

    // Builds the mask of valid character bits for the selected length.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            len_mask[i] = (i <= int'(top_idx));
        end
    end

    // Shifts right and places the new bit at the top of the character.
    always_comb begin
        shift_next          = shift_q >> 1;
        shift_next[top_idx] = rxd;
    end

    assign sync_masked = sync_char & len_mask;
    assign window_hit  = (shift_next == sync_masked);
    assign last_data   = (cnt_q == CNT_W'(top_idx));
    assign par_expect  = (^shift_q) ^ ~parity_even;
    assign hunting     = (phase_q == PH_HUNT);

    // Derives the per-bit event pulses from the current phase.
    always_comb begin
        char_valid = bit_strobe &&
                     (((phase_q == PH_DATA) && last_data && !parity_en) ||
                      (phase_q == PH_PARITY));
        char_data  = (phase_q == PH_PARITY) ? shift_q : shift_next;
        parity_bad = bit_strobe && (phase_q == PH_PARITY) && (rxd != par_expect);
        sync_seen  = (bit_strobe && (phase_q == PH_HUNT) && window_hit) ||
                     (char_valid && (char_data == sync_masked));
    end

    // Advances the hunt / data / parity sequence on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cmd_wr) begin
            phase_q <= cmd_hunt ? PH_HUNT : PH_DATA;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (force_align) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (bit_strobe) begin
            unique case (phase_q)
                PH_HUNT: begin
                    if (window_hit) begin
                        phase_q <= parity_en ? PH_SKIP_PAR : PH_DATA;
                        shift_q <= '0;
                        cnt_q   <= '0;
                    end else begin
                        shift_q <= shift_next;
                    end
                end
                PH_SKIP_PAR: begin
                    phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (last_data && parity_en) begin
                        phase_q <= PH_PARITY;
                        shift_q <= shift_next;
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (last_data) begin
                        shift_q <= '0;
                        cnt_q   <= '0;
                    end else begin
                        shift_q <= shift_next;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                PH_PARITY: begin
                    phase_q <= PH_DATA;
                    shift_q <= '0;
                    cnt_q   <= '0;
                end
                default: phase_q <= PH_DATA;
            endcase
        end
    end

    // R1
    // window_stable_chk
    window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe && !cmd_wr && !force_align) |=> $stable(shift_q));

    // R2
    // bit_count_bound_chk
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));
endmodule

// File: rtl/sr_status.sv
// Module: sr_status
// Receive buffer and status flags: ready, overrun, parity error and sync
// detect. Assumes the event pulses last one cycle each.
module sr_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              parity_bad,
    input  logic              sync_seen,
    input  logic              ext_sync_hit,
    input  logic              cmd_wr,
    input  logic              cmd_err_clr,
    input  logic              status_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun_err,
    output logic              parity_err,
    output logic              syndet
);
    // Loads the receive buffer and tracks whether it has been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (char_valid) begin
            rx_data  <= char_data;
            rx_ready <= 1'b1;
        end else if (data_rd) begin
            rx_ready <= 1'b0;
        end
    end

    // Maintains the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
        end else begin
            if (char_valid && rx_ready && !data_rd) overrun_err <= 1'b1;
            else if (cmd_wr && cmd_err_clr)         overrun_err <= 1'b0;
            if (parity_bad)                          parity_err  <= 1'b1;
            else if (cmd_wr && cmd_err_clr)         parity_err  <= 1'b0;
        end
    end

    // Sets sync detect on a sighting; clears it on status read or command.
    always_ff @(posedge clk) begin
        if (!rst_n)                        syndet <= 1'b0;
        else if (sync_seen || ext_sync_hit) syndet <= 1'b1;
        else if (status_rd || cmd_wr)      syndet <= 1'b0;
    end

    // R2
    // ready_rise_chk
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(char_valid));

    // R9
    // overrun_set_chk
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rx_ready && !data_rd) |=> overrun_err);

    // R6
    // syndet_clear_chk
    syndet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !sync_seen && !ext_sync_hit) |=> !syndet);
endmodule

// File: rtl/sync_hunt_rx.sv
// Module: sync_hunt_rx (top)
// Synchronous receiver with sync-character hunt, internal or external
// alignment, and a sync-detect pin. Assumes rxc and syn_in are slow
// relative to clk and already synchronous to it.
module sync_hunt_rx #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxc,
    input  logic              rxd,
    input  logic              rx_enable,
    input  logic [1:0]        len_code,
    input  logic              parity_en,
    input  logic              parity_even,
    input  logic              ext_sync_mode,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              syn_in,
    input  logic              cmd_wr,
    input  logic              cmd_hunt,
    input  logic              cmd_err_clr,
    input  logic              status_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              parity_err,
    output logic              overrun_err,
    output logic              syndet,
    output logic              hunting,
    output logic              syndet_out,
    output logic              syndet_oe
);
    logic rxc_rise;
    logic syn_rise;
    logic ext_armed_q;
    logic ext_hit;
    logic bit_strobe;
    logic char_valid;
    logic parity_bad;
    logic sync_seen;
    logic [DATA_W-1:0] char_data;

    sr_rise_detect u_rxc_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (rxc),
        .rise     (rxc_rise)
    );

    sr_rise_detect u_syn_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (syn_in),
        .rise     (syn_rise)
    );

    assign ext_hit = ext_sync_mode && syn_rise;

    // Tracks whether the external sync input has fired since the last hunt.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ext_armed_q <= 1'b0;
        else if (ext_hit)           ext_armed_q <= 1'b1;
        else if (cmd_wr && cmd_hunt) ext_armed_q <= 1'b0;
    end

    assign bit_strobe = rxc_rise && rx_enable && !cmd_wr && !ext_hit &&
                        (!ext_sync_mode || ext_armed_q);

    sr_deframer #(
        .DATA_W  (DATA_W),
        .MIN_LEN (MIN_LEN)
    ) u_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_strobe  (bit_strobe),
        .rxd         (rxd),
        .len_code    (len_code),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .sync_char   (sync_char),
        .cmd_wr      (cmd_wr),
        .cmd_hunt    (cmd_hunt),
        .force_align (ext_hit),
        .char_valid  (char_valid),
        .char_data   (char_data),
        .parity_bad  (parity_bad),
        .sync_seen   (sync_seen),
        .hunting     (hunting)
    );

    sr_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_valid   (char_valid),
        .char_data    (char_data),
        .parity_bad   (parity_bad),
        .sync_seen    (sync_seen),
        .ext_sync_hit (ext_hit),
        .cmd_wr       (cmd_wr),
        .cmd_err_clr  (cmd_err_clr),
        .status_rd    (status_rd),
        .data_rd      (data_rd),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .overrun_err  (overrun_err),
        .parity_err   (parity_err),
        .syndet       (syndet)
    );

    assign syndet_oe  = !ext_sync_mode;
    assign syndet_out = syndet_oe && syndet;

    // R7
    // ext_gate_chk
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sync_mode && !ext_armed_q) |-> !bit_strobe);
endmodule

// File: tb/tb_sync_hunt_rx.sv
module tb_sync_hunt_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxc = 1'b0, rxd = 1'b0, rx_enable = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       parity_en = 1'b0, parity_even = 1'b0, ext_sync_mode = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic       syn_in = 1'b0, cmd_wr = 1'b0, cmd_hunt = 1'b0, cmd_err_clr = 1'b0;
    logic       status_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, overrun_err, syndet, hunting, syndet_out, syndet_oe;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    sync_hunt_rx dut (
        .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .rx_enable(rx_enable),
        .len_code(len_code), .parity_en(parity_en), .parity_even(parity_even),
        .ext_sync_mode(ext_sync_mode), .sync_char(sync_char), .syn_in(syn_in),
        .cmd_wr(cmd_wr), .cmd_hunt(cmd_hunt), .cmd_err_clr(cmd_err_clr),
        .status_rd(status_rd), .data_rd(data_rd), .rx_data(rx_data),
        .rx_ready(rx_ready), .parity_err(parity_err), .overrun_err(overrun_err),
        .syndet(syndet), .hunting(hunting), .syndet_out(syndet_out),
        .syndet_oe(syndet_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rxd = b; rxc = 1'b1;
        repeat (2) @(negedge clk);
        rxc = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] ch, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(ch[i]);
    endtask

    task automatic command(input logic hunt, input logic eclr);
        @(negedge clk); cmd_wr = 1'b1; cmd_hunt = hunt; cmd_err_clr = eclr;
        @(negedge clk); cmd_wr = 1'b0; cmd_hunt = 1'b0; cmd_err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rd(input logic is_status);
        @(negedge clk); if (is_status) status_rd = 1'b1; else data_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0; data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 rx_ready", rx_ready, 0);
        check("R10 syndet", syndet, 0);
        check("R10 hunting", hunting, 0);
        check("R10 errors", {parity_err, overrun_err}, 0);
    endtask

    task automatic t_hunt_internal;
        rx_enable = 1'b1;
        command(1'b1, 1'b0);
        check("R3 hunting on", hunting, 1);
        send_bit(1); send_bit(1); send_bit(1);
        check("R3 still hunting", hunting, 1);
        send_char(8'h16, 8);
        check("R3 hunt ended", hunting, 0);
        check("R3 sync not delivered", rx_ready, 0);
        check("R3 syndet after match", syndet, 1);
        check("R8 pin follows", {syndet_oe, syndet_out}, 2'b11);
    endtask

    task automatic t_data_lsb;
        send_char(8'h41, 8);
        check("R2 rx_ready", rx_ready, 1);
        check("R2 data lsb first", rx_data, 8'h41);
        pulse_rd(1'b0);
        check("R2 read clears ready", rx_ready, 0);
        pulse_rd(1'b1);
        check("R6 status read clears", syndet, 0);
        check("R8 pin low", syndet_out, 0);
    endtask

    task automatic t_len5_parity_overrun;
        len_code = 2'd0; parity_en = 1'b1; parity_even = 1'b1;
        command(1'b1, 1'b0);
        send_bit(0); send_bit(1);
        send_char(8'h16, 5); send_bit(1'b1);
        check("R4 sync aligned", hunting, 0);
        send_char(8'h0B, 5); send_bit(1'b1);
        check("R2 len5 data", rx_data, 8'h0B);
        check("R4 good parity", parity_err, 0);
        send_char(8'h15, 5); send_bit(1'b0);
        check("R4 bad parity flagged", parity_err, 1);
        check("R4 char still delivered", rx_data, 8'h15);
        check("R9 overrun", overrun_err, 1);
    endtask

    task automatic t_sync_in_data;
        len_code = 2'd3; parity_en = 1'b0;
        command(1'b0, 1'b1);
        check("R10 errors cleared", {parity_err, overrun_err}, 0);
        check("R6 cmd clears syndet", syndet, 0);
        pulse_rd(1'b0);
        send_char(8'h16, 8);
        check("R5 sync data delivered", rx_data, 8'h16);
        check("R5 syndet on data", syndet, 1);
        pulse_rd(1'b0);
    endtask

    task automatic t_enable_gate;
        rx_enable = 1'b0;
        send_bit(1); send_bit(0); send_bit(1);
        check("R1 disabled no data", rx_ready, 0);
        rx_enable = 1'b1;
        send_char(8'h5A, 8);
        check("R1 disabled bits ignored", rx_data, 8'h5A);
        pulse_rd(1'b0);
    endtask

    task automatic t_external;
        ext_sync_mode = 1'b1;
        command(1'b1, 1'b0);
        check("R8 pin input", syndet_oe, 0);
        send_char(8'h3C, 8);
        check("R7 no bits before syn", rx_ready, 0);
        @(negedge clk); syn_in = 1'b1;
        repeat (2) @(negedge clk); syn_in = 1'b0;
        @(negedge clk);
        check("R7 syn ends hunt", hunting, 0);
        check("R7 syn sets syndet", syndet, 1);
        send_char(8'h3C, 8);
        check("R7 data after syn", rx_data, 8'h3C);
        check("R7 ready after syn", rx_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hunt_internal();
        t_data_lsb();
        t_len5_parity_overrun();
        t_sync_in_data();
        t_enable_gate();
        t_external();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule